// File: doc/BRIEF.md
# Sync-Started Falling Ramp Reference

This block generates the digital code that drives a DAC reference which falls once per PWM period. A sync pulse from the PWM timer reloads the code from a programmed start value and starts the ramp. While the ramp runs, the code drops by a programmed step every N clocks, where N is set by a step-rate prescaler. The code stops at zero.

A trip pulse from the comparator latch freezes the code for the rest of the period. Only the next sync pulse starts the ramp again. When sync and trip arrive in the same clock, the sync wins, so the new period still gets its ramp. The block also drives a flag that shows whether the ramp is running.

The start value is taken only at a sync pulse. Software may therefore write the value for the next period at any time without disturbing the current ramp.

Top module: `ramp_ref_gen`

## Requirements
- R1: After reset the block is idle: `running_o` is 0 and `code_o` equals `start_val_i` until the first sync pulse.
- R2: A cycle with `sync_i` high makes `code_o` equal the `start_val_i` of that cycle on the next clock, with `running_o` at 1.
- R3: While running, `code_o` drops by `step_i` once every `rate_div_i`+1 clocks. The first drop comes `rate_div_i`+1 clocks after the sync edge, and the code holds its value in the clocks between drops.
- R4: A cycle with `trip_i` high and `sync_i` low halts a running ramp: on the next clock `running_o` is 0 and `code_o` keeps the value it had, with no decrement in that cycle.
- R5: Once halted, the ramp stays halted with `code_o` frozen until a sync pulse. This holds even when the sync pulse arrives a long time later.
- R6: A change of `start_val_i` during a running or halted period has no effect on `code_o` until the next sync pulse.
- R7: When `sync_i` and `trip_i` are high in the same cycle, the sync takes priority: the ramp reloads and runs, and it decrements normally afterwards.
- R8: The code saturates at zero. A decrement larger than the current code yields 0, and `code_o` never rises while running except at a sync reload.
- R9: A trip pulse while idle (before any sync) is ignored: `running_o` stays 0 and `code_o` keeps following the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | PWM period sync pulse |
| trip_i | input | 1 | Trip status pulse from the comparator latch |
| start_val_i | input | CODE_W | Programmed ramp start code |
| step_i | input | CODE_W | Programmed decrement per step |
| rate_div_i | input | DIV_W | Prescaler: a step every rate_div_i+1 clocks |
| code_o | output | CODE_W | Current DAC code |
| running_o | output | 1 | 1 while the ramp is decrementing |

## Verification
The bench drives five trip and sync patterns:
- **Trip alone, mid-ramp:** shows that a halt freezes the code rather than reloading it.
- **Sync alone:** shows the reload and the step pacing with a prescaler above zero.
- **Sync and trip in the same cycle:** separates sync priority from trip priority; a design that favours the trip stays frozen.
- **Trip one cycle after sync:** shows that the halt can land before the first step, leaving the start value in place.
- **Idle trip and saturation:** a trip before any sync shows the idle state ignores trips, and a small start value with a zero prescaler shows the clamp at zero.

// File: rtl/ramp_ref_pkg.sv
package ramp_ref_pkg;

    parameter int unsigned DEF_CODE_W = 12;
    parameter int unsigned DEF_DIV_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } ramp_state_e;

    // Per-cycle command from control to datapath
    typedef struct packed {
        logic reload;   // take start value and begin period
        logic track;    // idle: follow start value
        logic dec;      // apply one saturating step
    } ramp_cmd_t;

endpackage

// File: rtl/ramp_prescaler.sv
module ramp_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             enable,
    input  logic [DIV_W-1:0] rate_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == rate_div);
    assign tick     = enable && at_limit;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (enable) begin
            if (at_limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
    import ramp_ref_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sync,
    input  logic        trip,
    input  logic        tick,
    output ramp_state_e state,
    output ramp_cmd_t   cmd
);
    ramp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (sync) begin
            state_d = ST_RUN;             // sync outranks trip
        end else if (trip && state_q == ST_RUN) begin
            state_d = ST_HALT;
        end
    end

    always_comb begin
        cmd        = '0;
        cmd.reload = sync;
        cmd.track  = !sync && (state_q == ST_IDLE);
        cmd.dec    = !sync && !trip && tick && (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
    import ramp_ref_pkg::*;
#(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_cmd_t         cmd,
    input  logic [CODE_W-1:0] start_val,
    input  logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] stepped;

    // Saturating subtract: clamp at zero instead of wrapping
    assign stepped = (code_q >= step) ? (code_q - step) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= start_val;
        end else if (cmd.reload || cmd.track) begin
            code_q <= start_val;
        end else if (cmd.dec) begin
            code_q <= stepped;
        end
    end

    assign code = code_q;
endmodule

// File: rtl/ramp_ref_gen.sv
module ramp_ref_gen
    import ramp_ref_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned DIV_W  = DEF_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              trip_i,
    input  logic [CODE_W-1:0] start_val_i,
    input  logic [CODE_W-1:0] step_i,
    input  logic [DIV_W-1:0]  rate_div_i,
    output logic [CODE_W-1:0] code_o,
    output logic              running_o
);
    ramp_state_e state;
    ramp_cmd_t   cmd;
    logic        tick;

    ramp_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (sync_i),
        .enable   (state == ST_RUN),
        .rate_div (rate_div_i),
        .tick     (tick)
    );

    ramp_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .sync  (sync_i),
        .trip  (trip_i),
        .tick  (tick),
        .state (state),
        .cmd   (cmd)
    );

    ramp_datapath #(.CODE_W(CODE_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .start_val (start_val_i),
        .step      (step_i),
        .code      (code_o)
    );

    assign running_o = (state == ST_RUN);
endmodule

// File: rtl/ramp_ref_checker.sv
module ramp_ref_checker #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned DIV_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_i,
    input logic              trip_i,
    input logic [CODE_W-1:0] start_val_i,
    input logic [CODE_W-1:0] step_i,
    input logic [DIV_W-1:0]  rate_div_i,
    input logic [CODE_W-1:0] code_o,
    input logic              running_o
);
    p_sync_runs_r2: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> running_o);

    p_sync_loads_r2: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> code_o == $past(start_val_i));

    p_trip_halts_r4: assert property (@(posedge clk) disable iff (rst)
        (trip_i && !sync_i) |=> !running_o);

    p_trip_freezes_r4: assert property (@(posedge clk) disable iff (rst)
        (running_o && trip_i && !sync_i) |=> $stable(code_o));

    p_halt_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !sync_i) |=> !running_o);

    p_stopped_code_r6: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !sync_i && $stable(start_val_i)) |=> $stable(code_o));

    p_step_size_r3: assert property (@(posedge clk) disable iff (rst)
        (running_o && !sync_i) |=>
            (code_o == $past(code_o)) ||
            (code_o == $past(code_o) - $past(step_i)) ||
            (code_o == '0));

    p_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (running_o && !sync_i) |=> code_o <= $past(code_o));
endmodule

bind ramp_ref_gen ramp_ref_checker #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (sync_i),
    .trip_i      (trip_i),
    .start_val_i (start_val_i),
    .step_i      (step_i),
    .rate_div_i  (rate_div_i),
    .code_o      (code_o),
    .running_o   (running_o)
);

// File: tb/ramp_ref_gen_test.sv
module ramp_ref_gen_test;
    localparam int CW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_i = 1'b0;
    logic          trip_i = 1'b0;
    logic [CW-1:0] start_val_i = 12'd100;
    logic [CW-1:0] step_i = 12'd7;
    logic [DW-1:0] rate_div_i = 8'd2;
    logic [CW-1:0] code_o;
    logic          running_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ramp_ref_gen #(.CODE_W(CW), .DIV_W(DW)) uut (
        .clk(clk), .rst(rst), .sync_i(sync_i), .trip_i(trip_i),
        .start_val_i(start_val_i), .step_i(step_i), .rate_div_i(rate_div_i),
        .code_o(code_o), .running_o(running_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit s, input bit t);
        sync_i = s;
        trip_i = t;
        @(negedge clk);
        sync_i = 1'b0;
        trip_i = 1'b0;
    endtask

    task automatic t_reset_idle;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        check("R1 running after reset", running_o, 0);
        check("R1 code after reset", code_o, 100);
        pulse(1'b0, 1'b1);
        check("R9 idle trip running", running_o, 0);
        cyc(3);
        check("R9 idle trip code", code_o, 100);
    endtask

    task automatic t_sync_alone;
        pulse(1'b1, 1'b0);
        check("R2 sync running", running_o, 1);
        check("R2 sync code", code_o, 100);
        cyc(2);
        check("R3 hold between steps", code_o, 100);
        cyc(1);
        check("R3 first step", code_o, 93);
        start_val_i = 12'd50;
        cyc(3);
        check("R3 second step", code_o, 86);
        check("R6 start change ignored mid-run", code_o, 86);
    endtask

    task automatic t_trip_alone;
        pulse(1'b0, 1'b1);
        check("R4 trip running", running_o, 0);
        check("R4 trip code frozen", code_o, 86);
        cyc(10);
        check("R5 halted running", running_o, 0);
        check("R5 halted code", code_o, 86);
        check("R6 start change ignored while halted", code_o, 86);
    endtask

    task automatic t_same_cycle;
        pulse(1'b1, 1'b1);
        check("R7 sync+trip running", running_o, 1);
        check("R7 sync+trip reload", code_o, 50);
        cyc(3);
        check("R7 steps after sync+trip", code_o, 43);
    endtask

    task automatic t_trip_after_sync;
        start_val_i = 12'd200;
        pulse(1'b1, 1'b0);
        check("R2 reload 200", code_o, 200);
        pulse(1'b0, 1'b1);
        check("R4 trip after sync running", running_o, 0);
        check("R4 trip after sync code", code_o, 200);
        cyc(5);
        check("R5 stays halted", code_o, 200);
    endtask

    task automatic t_saturate;
        start_val_i = 12'd10;
        step_i      = 12'd4;
        rate_div_i  = 8'd0;
        pulse(1'b1, 1'b0);
        check("R8 reload 10", code_o, 10);
        cyc(1);
        check("R3 div0 step", code_o, 6);
        cyc(1);
        check("R8 step to 2", code_o, 2);
        cyc(1);
        check("R8 clamp zero", code_o, 0);
        cyc(2);
        check("R8 stays zero", code_o, 0);
        check("R8 still running", running_o, 1);
    endtask

    initial begin
        t_reset_idle();
        t_sync_alone();
        t_trip_alone();
        t_same_cycle();
        t_trip_after_sync();
        t_saturate();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule